// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds eight identical down-counting timers behind one small register window. Each channel has a control register and a count register, eight bytes apart from the next channel. Each channel drives its own interrupt line. A channel can be stopped, run freely, expire once, or expire over and over while reloading the count it was given. A free-running channel loaded with all ones, read and bit-inverted, gives a rising time base. A one-shot event is armed by writing 0 to the control register, writing the count, and then enabling the channel in one-shot mode.

Each channel is a four-state machine. The states are OFF, FREE, ONCE and PERIOD.

A control write moves the channel from any state. With bit 0 clear the channel goes to OFF. With bit 0 set the mode field picks the next state: 1 gives ONCE, 2 gives PERIOD, and 0 or 3 gives FREE.

Without a bus write the machine runs on its own:
- ONCE goes to OFF on expiry (the step taken at a count of 0).
- PERIOD stays in PERIOD on expiry and reloads its count.
- FREE stays in FREE and wraps its count.
- OFF stays in OFF.

A count of N gives N+1 clock cycles between the enabling write and the interrupt pulse.

Top module: `tmr_bank`

## Requirements
- R1: After reset every channel is in OFF, its counter and reload value are 0, every interrupt line is low, and every register reads 0.
- R2: Channel t decodes its control register at byte address t*8 and its count register at t*8+4. Every other byte offset inside a channel's 8-byte slot reads 0, and a write to it changes nothing.
- R3: The control register reads back the enable state in bit 0 and the last written mode in bits [5:4]. All other bits read 0, whatever was written to them.
- R4: Reading the count register returns the live counter. Writing the count register loads both the counter and the reload value, whether or not the channel is enabled.
- R5: An enabled channel decrements its counter by one per clock. A channel in OFF holds its counter.
- R6: In one-shot mode (mode 1), the clock edge that finds a count of 0 clears the enable bit and raises that channel's interrupt for exactly one cycle. The pulse comes N+1 cycles after the enabling write.
- R7: In periodic mode (mode 2), the clock edge that finds a count of 0 reloads the counter from the reload value, keeps the channel enabled, and pulses the interrupt once. The pulses repeat every N+1 cycles.
- R8: In free-running mode (mode 0, and mode 3 likewise), the counter wraps from 0 to 0xFFFFFFFF and no interrupt is ever raised.
- R9: Writing 0 to the control register stops the channel at once. The counter keeps its value and no interrupt follows.
- R10: Each channel's expiry appears only on interrupt line t of that channel. Channels run independently.
- R11: A bus write to a channel in the same cycle as its expiry takes priority: the write is applied and that expiry neither reloads nor pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte address, used for both write and read |
| bus_wdata | input | 32 | Write data; the control register takes bits 0 and [5:4] |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 8 | One interrupt line per channel, bit t for channel t |

## Verification
Directed sequences run each mode on its own channel.
- A one-shot with a count of 3 shows whether the pulse comes on cycle N+1 and whether the enable bit drops.
- A periodic channel with a count of 2 shows whether reloading and repeated pulses line up.
- A free-running channel with a count of 1 shows whether the counter wraps without an interrupt.
- Writes to misaligned offsets and a 0xFF control byte separate a correct decode and readback from a loose one.
- A count write placed exactly on an expiry cycle shows the write priority.

A long seeded random run then mixes writes of every kind across all eight channels with small counts. Expiries then collide with rewrites and stops, and each cycle's interrupt vector and read data are compared against a model built from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_FREE   = 2'd1,
        ST_ONCE   = 2'd2,
        ST_PERIOD = 2'd3
    } chan_state_e;

    localparam logic [1:0] MODE_ONCE   = 2'd1;
    localparam logic [1:0] MODE_PERIOD = 2'd2;

    // Mode field to running state; 0 and 3 both run freely.
    function automatic chan_state_e run_state(input logic [1:0] mode);
        case (mode)
            MODE_ONCE:   return ST_ONCE;
            MODE_PERIOD: return ST_PERIOD;
            default:     return ST_FREE;
        endcase
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int NCH = 8
) (
    input  logic                     bus_wr,
    input  logic [$clog2(NCH)+2:0]   bus_addr,
    output logic [NCH-1:0]           ctrl_we,
    output logic [NCH-1:0]           cnt_we,
    output logic [$clog2(NCH)-1:0]   rd_chan,
    output logic                     rd_ctrl,
    output logic                     rd_cnt
);
    localparam int CH_W = $clog2(NCH);

    logic [CH_W-1:0] chan;
    logic            chan_ok;

    assign chan    = bus_addr[CH_W+2:3];
    assign chan_ok = (32'(chan) < NCH);
    assign rd_chan = chan;
    assign rd_ctrl = chan_ok && (bus_addr[2:0] == 3'd0);
    assign rd_cnt  = chan_ok && (bus_addr[2:0] == 3'd4);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ctrl_we[i] = bus_wr && rd_ctrl && (chan == CH_W'(i));
            cnt_we[i]  = bus_wr && rd_cnt  && (chan == CH_W'(i));
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          ctrl_en,
    input  logic [1:0]    ctrl_mode,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    output logic [CW-1:0] count_o,
    output logic          en_o,
    output logic [1:0]    mode_o,
    output logic          irq_o
);
    chan_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] rel_q, rel_d;
    logic [1:0]    mode_q, mode_d;
    logic          fire;
    logic          irq_q;
    logic          bus_hit;
    logic          at_zero;

    assign bus_hit = ctrl_we || cnt_we;
    assign at_zero = (cnt_q == '0);

    // Next-state and datapath decision
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        rel_d  = rel_q;
        mode_d = mode_q;
        fire   = 1'b0;
        if (ctrl_we) begin
            mode_d = ctrl_mode;
            st_d   = ctrl_en ? run_state(ctrl_mode) : ST_OFF;
        end else if (cnt_we) begin
            cnt_d = cnt_wdata;
            rel_d = cnt_wdata;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                end
                ST_FREE: begin
                    cnt_d = cnt_q - 1'b1;
                end
                ST_ONCE: begin
                    if (at_zero) begin
                        st_d = ST_OFF;
                        fire = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_PERIOD: begin
                    if (at_zero) begin
                        cnt_d = rel_q;
                        fire  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            cnt_q  <= '0;
            rel_q  <= '0;
            mode_q <= 2'd0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            rel_q  <= rel_d;
            mode_q <= mode_d;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fire;
    end

    assign count_o = cnt_q;
    assign en_o    = (st_q != ST_OFF);
    assign mode_o  = mode_q;
    assign irq_o   = irq_q;

    p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_OFF && !at_zero && !bus_hit) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && !bus_hit) |=> ($stable(cnt_q) && !irq_q));

    p_once_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ONCE && at_zero && !bus_hit) |=> (st_q == ST_OFF && irq_q));

    p_period_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PERIOD && at_zero && !bus_hit) |=>
            (st_q == ST_PERIOD && cnt_q == $past(rel_q) && irq_q));

    p_free_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FREE && at_zero && !bus_hit) |=> (cnt_q == '1 && !irq_q));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(st_q) == ST_ONCE || $past(st_q) == ST_PERIOD));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |=> !irq_q);

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
    parameter int NCH    = 8,
    parameter int CW     = 32,
    parameter int ADDR_W = $clog2(NCH) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CW-1:0]     bus_wdata,
    output logic [CW-1:0]     bus_rdata,
    output logic [NCH-1:0]    irq
);
    localparam int CH_W = $clog2(NCH);

    logic [NCH-1:0]  ctrl_we;
    logic [NCH-1:0]  cnt_we;
    logic [CH_W-1:0] rd_chan;
    logic            rd_ctrl;
    logic            rd_cnt;
    logic [CW-1:0]   ch_count [NCH];
    logic            ch_en    [NCH];
    logic [1:0]      ch_mode  [NCH];

    tmr_decode #(.NCH(NCH)) u_decode (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .ctrl_we (ctrl_we),
        .cnt_we  (cnt_we),
        .rd_chan (rd_chan),
        .rd_ctrl (rd_ctrl),
        .rd_cnt  (rd_cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tmr_channel #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (ctrl_we[g]),
            .ctrl_en  (bus_wdata[0]),
            .ctrl_mode(bus_wdata[5:4]),
            .cnt_we   (cnt_we[g]),
            .cnt_wdata(bus_wdata),
            .count_o  (ch_count[g]),
            .en_o     (ch_en[g]),
            .mode_o   (ch_mode[g]),
            .irq_o    (irq[g])
        );
    end

    always_comb begin
        if (rd_ctrl)
            bus_rdata = {{(CW-6){1'b0}}, ch_mode[rd_chan], 3'b000, ch_en[rd_chan]};
        else if (rd_cnt)
            bus_rdata = ch_count[rd_chan];
        else
            bus_rdata = '0;
    end

    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_we, cnt_we}));

    p_no_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] != 2'b00) |-> ({ctrl_we, cnt_we} == '0));

endmodule

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    string tag = "R1";

    logic        m_en   [NCH];
    logic [1:0]  m_mode [NCH];
    logic [31:0] m_cnt  [NCH];
    logic [31:0] m_rel  [NCH];
    logic [7:0]  m_irq;

    always #4 clk = ~clk;

    tmr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        int ch;
        ch = int'(a[5:3]);
        case (a[2:0])
            3'd0:    return {26'd0, m_mode[ch], 3'b000, m_en[ch]};
            3'd4:    return m_cnt[ch];
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_en[c] = 1'b0; m_mode[c] = 2'd0; m_cnt[c] = '0; m_rel[c] = '0;
        end
        m_irq = '0;
    endtask

    // One clock of the requirement model (R4..R11)
    task automatic model_step(input logic wr, input logic [5:0] a, input logic [31:0] d);
        logic [7:0] nirq;
        nirq = '0;
        for (int c = 0; c < NCH; c++) begin
            if (wr && a == 6'(c * 8)) begin
                m_en[c] = d[0]; m_mode[c] = d[5:4];
            end else if (wr && a == 6'(c * 8 + 4)) begin
                m_cnt[c] = d; m_rel[c] = d;
            end else if (m_en[c]) begin
                if (m_cnt[c] == 0) begin
                    if (m_mode[c] == 2'd1) begin
                        m_en[c] = 1'b0; nirq[c] = 1'b1;
                    end else if (m_mode[c] == 2'd2) begin
                        m_cnt[c] = m_rel[c]; nirq[c] = 1'b1;
                    end else begin
                        m_cnt[c] = 32'hFFFF_FFFF;
                    end
                end else begin
                    m_cnt[c] = m_cnt[c] - 1;
                end
            end
        end
        m_irq = nirq;
    endtask

    task automatic compare();
        n_chk++;
        if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL %s irq: actual %h expected %h", tag, irq, m_irq);
        end
        n_chk++;
        if (bus_rdata !== exp_read(bus_addr)) begin
            n_bad++;
            $display("FAIL %s read @%h: actual %h expected %h", tag, bus_addr,
                     bus_rdata, exp_read(bus_addr));
        end
    endtask

    task automatic step(input logic wr, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        compare();
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step(wr, a, d);
    endtask

    task automatic idle(input int n, input logic [5:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, 32'd0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);

        // R1: reset state on every register
        tag = "R1";
        for (int a = 0; a < 64; a++) step(1'b0, 6'(a), 32'd0);

        // R2: misaligned offsets ignored, read zero
        tag = "R2";
        step(1'b1, 6'd20, 32'd77);
        for (int o = 1; o < 8; o++)
            if (o != 4) step(1'b1, 6'(16 + o), 32'hFFFF_FFFF);
        for (int o = 0; o < 8; o++) step(1'b0, 6'(16 + o), 32'd0);

        // R3: control byte 0xFF reads back enable and mode only
        tag = "R3";
        step(1'b1, 6'd24, 32'h0000_FFFF);
        idle(2, 6'd24);
        step(1'b1, 6'd24, 32'd0);
        idle(1, 6'd24);

        // R4 R5: live count while free-running, rewrite while enabled
        tag = "R5";
        step(1'b1, 6'd4, 32'd10);
        step(1'b1, 6'd0, 32'h01);
        idle(4, 6'd4);
        tag = "R4";
        step(1'b1, 6'd4, 32'd100);
        idle(3, 6'd4);

        // R6: one-shot count 3, pulse on cycle 4
        tag = "R6";
        step(1'b1, 6'd20, 32'd3);
        step(1'b1, 6'd16, 32'h11);
        idle(7, 6'd16);

        // R7: periodic count 2
        tag = "R7";
        step(1'b1, 6'd44, 32'd2);
        step(1'b1, 6'd40, 32'h21);
        idle(10, 6'd44);

        // R8: free run wraps, no pulse; mode 3 likewise
        tag = "R8";
        step(1'b1, 6'd12, 32'd1);
        step(1'b1, 6'd8, 32'h01);
        idle(4, 6'd12);
        step(1'b1, 6'd56, 32'h31);
        idle(3, 6'd60);

        // R9: stop holds count
        tag = "R9";
        step(1'b1, 6'd40, 32'd0);
        idle(4, 6'd44);
        step(1'b1, 6'd8, 32'd0);
        idle(2, 6'd12);

        // R11: count write on the expiry cycle of a periodic channel
        tag = "R11";
        step(1'b1, 6'd52, 32'd1);
        step(1'b1, 6'd48, 32'h21);
        step(1'b0, 6'd52, 32'd0);
        step(1'b1, 6'd52, 32'd5);
        idle(8, 6'd52);

        // R10: several channels at once, random mix
        tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            int ch;
            logic [5:0] a;
            logic [31:0] d;
            ch = int'($urandom_range(0, 7));
            case ($urandom_range(0, 9))
                0, 1: a = 6'(ch * 8);
                2, 3: a = 6'(ch * 8 + 4);
                default: a = 6'($urandom_range(0, 63));
            endcase
            if (a[2:0] == 3'd0)
                d = {$urandom_range(0, 3) == 0 ? 24'hABCDEF : 24'd0, 8'($urandom)};
            else if ($urandom_range(0, 15) == 0)
                d = $urandom;
            else
                d = 32'($urandom_range(0, 12));
            step($urandom_range(0, 9) < 3, a, d);
        end

        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule